// File: doc/BRIEF.md
# Descriptor Ring Doorbell Tracker

This block keeps the producer and consumer accounting for a circular queue of work descriptors in an offload engine. Software never writes absolute pointers: it reports newly queued descriptors as a count written to an add register, and it reports retired descriptors as a count written to a deallocate register. The block turns these counts into an available count for the engine, a processing index, a pending-completion count and a next-to-retire index, each wrapping at the programmed ring size.

A stub completion input stands in for the engine. The block raises `fetch_valid` while the engine is enabled and has work. Each completion pulse accepted while `fetch_valid` is high moves one descriptor from the available count to the pending-completion count. Software reads a packed done-status word that holds the pending count and the next index to retire. A halt register stops the engine. The ring size and the descriptor width are configuration registers. Memory fetch, the contents of descriptors and the movement of data are outside this block.

Register selects on `reg_addr`: 0 ring size, 1 descriptor width, 2 add count, 3 deallocate count, 4 halt. Add and deallocate counts are taken from `reg_wdata[14:0]`.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the engine is halted, the ring size is 1024, the pending count and both indices are 0, `fetch_valid`, `dealloc_err` and `desc_wide` are 0.
- R2: A write of N to select 2 adds N to the available count. `fetch_valid` then stays high for exactly N more accepted completions, unless the engine is halted.
- R3: `fetch_valid` is high only when the engine is enabled and the available count is nonzero. A completion pulse while `fetch_valid` is low changes no state.
- R4: Each accepted completion raises the pending count by 1 and advances `fetch_idx` by 1, wrapping to 0 at the ring size.
- R5: A write of N to select 3 with N not above the pending count lowers the pending count by N and advances the retire index by N modulo the ring size.
- R6: A write of N to select 3 with N above the pending count retires only the pending descriptors, leaves the pending count at 0 and sets `dealloc_err`. That flag stays set until reset.
- R7: `done_status[14:0]` is the pending count and `done_status[28:16]` is the next-to-retire index. Bits 15 and 31:29 are 0. The word reflects a completion or deallocate in the cycle after the clock edge that takes it.
- R8: All indices wrap to 0 when they reach the active ring size (default 1024).
- R9: A write to select 4 with bit 0 set halts the engine. A write with bit 0 clear enables it. `engine_on` shows the state.
- R10: A write to select 0 stages a ring size from `reg_wdata[13:0]`. A value of 0 or above 8192 is ignored. The staged size becomes active only on cycles when the engine is halted. A size written while the engine runs has no effect until the engine is halted.
- R11: A write of 1 to select 1 chooses 32-byte descriptors (`desc_wide`=0). A write of 7 chooses 128-byte descriptors (`desc_wide`=1). Other values, and writes to selects 5 to 7, change nothing.
- R12: A completion and a deallocate in the same cycle combine: the new pending count is the old count minus the retired amount plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| eng_done | input | 1 | Completion pulse from the engine stub |
| fetch_valid | output | 1 | Engine may work on the descriptor at `fetch_idx` |
| fetch_idx | output | 13 | Ring index of the next descriptor to process |
| done_status | output | 32 | Packed pending count and next-to-retire index |
| desc_wide | output | 1 | 1 selects 128-byte descriptors, 0 selects 32-byte |
| engine_on | output | 1 | Engine enabled |
| dealloc_err | output | 1 | Sticky over-retire flag |

## Verification
The assertions check several rules on every cycle. A halted engine never offers work. The processing index moves only on an accepted completion. A completion alone adds exactly one to the pending count, and an in-range retire alone subtracts exactly its count. Over-retire saturates and latches the error. The spare status bits stay zero. The bench sweeps add sizes, completion gaps and retire splits over a 16-entry ring against an arithmetic model that uses modulo. Only those scenarios can show wrap at the default 1024 entries, the deferred effect of a size written while running, and the descriptor-width decode.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int PEND_W   = 15;
  localparam int RIDX_W   = 13;
  localparam int SIZE_W   = RIDX_W + 1;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int MAX_RING = 1 << RIDX_W;

  localparam logic [ADDR_W-1:0] SEL_SIZE   = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_WIDTH  = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_ADD    = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_RETIRE = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_HALT   = 3'd4;

  localparam logic [DATA_W-1:0] WIDTH_NARROW = 32'd1;
  localparam logic [DATA_W-1:0] WIDTH_WIDE   = 32'd7;

  // Advance an index by n places, wrapping at size. Valid when idx < size and n <= size.
  function automatic logic [RIDX_W-1:0] ring_advance(input logic [RIDX_W-1:0] idx,
                                                     input logic [PEND_W-1:0] n,
                                                     input logic [SIZE_W-1:0] size);
    logic [PEND_W:0] sum;
    sum = (PEND_W+1)'(idx) + (PEND_W+1)'(n);
    if (sum >= (PEND_W+1)'(size)) sum = sum - (PEND_W+1)'(size);
    return sum[RIDX_W-1:0];
  endfunction

  // Build the done-status word from the pending count and the retire index.
  function automatic logic [DATA_W-1:0] pack_done(input logic [PEND_W-1:0] pend,
                                                  input logic [RIDX_W-1:0] idx);
    return {3'b000, idx, 1'b0, pend};
  endfunction
endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import ring_pkg::*;
#(
  parameter int DEF_RING = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_sel,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              engine_on,
  output logic [SIZE_W-1:0] ring_sz,
  output logic              desc_wide
);
  logic [SIZE_W-1:0] stage_sz;
  logic              halted;
  logic [SIZE_W-1:0] size_val;
  logic              size_ok;

  assign size_val  = cfg_data[SIZE_W-1:0];
  assign size_ok   = (size_val != '0) && (size_val <= SIZE_W'(MAX_RING));
  assign engine_on = !halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted    <= 1'b1;
      stage_sz  <= SIZE_W'(DEF_RING);
      ring_sz   <= SIZE_W'(DEF_RING);
      desc_wide <= 1'b0;
    end else begin
      if (halted) ring_sz <= stage_sz;
      if (cfg_we && cfg_sel == SEL_SIZE && size_ok) stage_sz <= size_val;
      if (cfg_we && cfg_sel == SEL_WIDTH) begin
        if (cfg_data == WIDTH_NARROW)    desc_wide <= 1'b0;
        else if (cfg_data == WIDTH_WIDE) desc_wide <= 1'b1;
      end
      if (cfg_we && cfg_sel == SEL_HALT) halted <= cfg_data[0];
    end
  end
endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
  import ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              engine_on,
  input  logic [SIZE_W-1:0] ring_sz,
  input  logic              add_wr,
  input  logic [PEND_W-1:0] add_n,
  input  logic              eng_done,
  output logic              fetch_valid,
  output logic [RIDX_W-1:0] fetch_idx,
  output logic              take
);
  logic [PEND_W-1:0] avail;
  logic [PEND_W-1:0] avail_nxt;
  logic [RIDX_W-1:0] idx_nxt;

  assign fetch_valid = engine_on && (avail != '0);
  assign take        = eng_done && fetch_valid;
  assign idx_nxt     = ring_advance(fetch_idx, PEND_W'(1), ring_sz);

  always_comb begin
    avail_nxt = avail;
    if (add_wr) avail_nxt = avail_nxt + add_n;
    if (take)   avail_nxt = avail_nxt - PEND_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail     <= '0;
      fetch_idx <= '0;
    end else begin
      avail <= avail_nxt;
      if (take) fetch_idx <= idx_nxt;
    end
  end
endmodule

// File: rtl/ring_retire.sv
module ring_retire
  import ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] ring_sz,
  input  logic              take,
  input  logic              ret_wr,
  input  logic [PEND_W-1:0] ret_n,
  output logic [PEND_W-1:0] pend,
  output logic [RIDX_W-1:0] rd_idx,
  output logic              err
);
  logic              over;
  logic [PEND_W-1:0] ret_amt;
  logic [PEND_W-1:0] pend_nxt;
  logic [RIDX_W-1:0] rd_nxt;

  assign over     = ret_wr && (ret_n > pend);
  assign ret_amt  = !ret_wr ? '0 : (over ? pend : ret_n);
  assign pend_nxt = pend - ret_amt + PEND_W'(take);
  assign rd_nxt   = ring_advance(rd_idx, ret_amt, ring_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      rd_idx <= '0;
      err    <= 1'b0;
    end else begin
      pend   <= pend_nxt;
      rd_idx <= rd_nxt;
      if (over) err <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import ring_pkg::*;
#(
  parameter int DEF_RING = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              eng_done,
  output logic              fetch_valid,
  output logic [RIDX_W-1:0] fetch_idx,
  output logic [DATA_W-1:0] done_status,
  output logic              desc_wide,
  output logic              engine_on,
  output logic              dealloc_err
);
  logic [SIZE_W-1:0] ring_sz;
  logic              add_wr;
  logic              ret_wr;
  logic [PEND_W-1:0] wr_count;
  logic              take;
  logic [PEND_W-1:0] pend;
  logic [RIDX_W-1:0] rd_idx;

  assign add_wr   = reg_we && reg_addr == SEL_ADD;
  assign ret_wr   = reg_we && reg_addr == SEL_RETIRE;
  assign wr_count = reg_wdata[PEND_W-1:0];

  ring_cfg #(.DEF_RING(DEF_RING)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(reg_we), .cfg_sel(reg_addr), .cfg_data(reg_wdata),
    .engine_on(engine_on), .ring_sz(ring_sz), .desc_wide(desc_wide)
  );

  ring_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .engine_on(engine_on), .ring_sz(ring_sz),
    .add_wr(add_wr), .add_n(wr_count), .eng_done(eng_done),
    .fetch_valid(fetch_valid), .fetch_idx(fetch_idx), .take(take)
  );

  ring_retire u_retire (
    .clk(clk), .rst_n(rst_n), .ring_sz(ring_sz), .take(take),
    .ret_wr(ret_wr), .ret_n(wr_count),
    .pend(pend), .rd_idx(rd_idx), .err(dealloc_err)
  );

  assign done_status = pack_done(pend, rd_idx);
endmodule

// File: rtl/ring_tracker_chk.sv
module ring_tracker_chk
  import ring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [RIDX_W-1:0] fetch_idx,
  input logic              engine_on,
  input logic [DATA_W-1:0] done_status,
  input logic              dealloc_err,
  input logic [SIZE_W-1:0] ring_sz,
  input logic              take,
  input logic              ret_wr,
  input logic [PEND_W-1:0] ret_n,
  input logic [PEND_W-1:0] pend
);
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(fetch_idx));

  // R9
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_on |-> !fetch_valid);

  // R4
  take_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ret_wr) |=> pend == PEND_W'($past(pend) + PEND_W'(1)));

  // R5
  retire_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_wr && ret_n <= pend && !take) |=> pend == PEND_W'($past(pend) - $past(ret_n)));

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_wr && ret_n > pend) |=> dealloc_err && pend == PEND_W'($past(take)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dealloc_err |=> dealloc_err);

  // R7
  layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_status[15] == 1'b0 && done_status[31:29] == 3'b000 && done_status[14:0] == pend);

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> SIZE_W'(fetch_idx) < ring_sz);
endmodule

bind desc_ring_tracker ring_tracker_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
  .engine_on(engine_on), .done_status(done_status), .dealloc_err(dealloc_err),
  .ring_sz(ring_sz), .take(take), .ret_wr(ret_wr), .ret_n(wr_count), .pend(pend)
);

// File: tb/test_desc_ring_tracker.sv
`timescale 1ns/1ps
module test_desc_ring_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        eng_done = 1'b0;
  logic        fetch_valid;
  logic [12:0] fetch_idx;
  logic [31:0] done_status;
  logic        desc_wide;
  logic        engine_on;
  logic        dealloc_err;

  int checks = 0;
  int failures = 0;

  int m_avail = 0, m_pend = 0, m_proc = 0, m_rd = 0;
  int m_size = 1024, m_stage = 1024;
  bit m_err = 0, m_on = 0, m_wide = 0;

  always #4 clk = ~clk;

  desc_ring_tracker i_desc_ring_tracker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .eng_done(eng_done), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
    .done_status(done_status), .desc_wide(desc_wide), .engine_on(engine_on),
    .dealloc_err(dealloc_err)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "pending", longint'(done_status[14:0]), m_pend);
    chk(tag, "retire_idx", longint'(done_status[28:16]), m_rd);
    chk(tag, "spare_bits", longint'({done_status[31:29], done_status[15]}), 0);
    chk(tag, "fetch_valid", longint'(fetch_valid), longint'(m_on && m_avail != 0));
    chk(tag, "fetch_idx", longint'(fetch_idx), m_proc);
    chk(tag, "dealloc_err", longint'(dealloc_err), longint'(m_err));
    chk(tag, "engine_on", longint'(engine_on), longint'(m_on));
    chk(tag, "desc_wide", longint'(desc_wide), longint'(m_wide));
  endtask

  // One clock: drive, update the model from the pre-edge state, then compare.
  task automatic step(string tag, bit we, int addr, int data, bit done);
    bit acc;
    int ret;
    bit over;
    reg_we = we; reg_addr = 3'(addr); reg_wdata = 32'(data); eng_done = done;
    acc = done && m_on && (m_avail != 0);
    ret = 0; over = 0;
    if (we && addr == 3) begin
      if (data > m_pend) begin ret = m_pend; over = 1; end
      else ret = data;
    end
    m_proc  = (m_proc + int'(acc)) % m_size;
    m_rd    = (m_rd + ret) % m_size;
    m_pend  = m_pend - ret + int'(acc);
    m_avail = m_avail + ((we && addr == 2) ? data : 0) - int'(acc);
    if (over) m_err = 1;
    if (!m_on) m_size = m_stage;
    if (we && addr == 0 && data > 0 && data <= 8192) m_stage = data;
    if (we && addr == 1 && data == 1) m_wide = 0;
    if (we && addr == 1 && data == 7) m_wide = 1;
    if (we && addr == 4) m_on = !data[0];
    @(posedge clk); #1;
    reg_we = 1'b0; eng_done = 1'b0;
    check_all(tag);
  endtask

  task automatic drain(string tag);
    int c = 0;
    while (m_avail != 0 && c < 5000) begin
      step(tag, 0, 0, 0, 1);
      c++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    check_all("R1");

    // R11: descriptor width decode, ignored values and ignored selects
    step("R11", 1, 1, 7, 0);
    step("R11", 1, 1, 3, 0);
    step("R11", 1, 5, 1, 0);
    step("R11", 1, 7, 1, 0);
    chk("R11", "wide_kept", longint'(desc_wide), 1);
    step("R11", 1, 1, 1, 0);
    chk("R11", "narrow", longint'(desc_wide), 0);

    // R3: completions while halted or without work change nothing
    step("R3", 0, 0, 0, 1);
    step("R2", 1, 2, 3, 0);
    step("R3", 0, 0, 0, 1);
    chk("R3", "halted_no_take", longint'(fetch_idx), 0);
    step("R9", 1, 4, 0, 0);
    chk("R9", "enabled", longint'(fetch_valid), 1);

    // R8: wrap at default 1024 entries
    step("R2", 1, 2, 1027, 0);
    drain("R8");
    chk("R8", "wrap_default", longint'(fetch_idx), 6);
    step("R5", 1, 3, 1000, 0);
    step("R8", 1, 3, 30, 0);
    chk("R8", "retire_wrap", longint'(done_status[28:16]), 6);
    step("R3", 0, 0, 0, 1);

    // R10: size staged while halted, applied before enabling
    step("R9", 1, 4, 1, 0);
    chk("R9", "halted", longint'(fetch_valid), 0);
    step("R10", 1, 0, 16, 0);
    step("R10", 0, 0, 0, 0);
    step("R9", 1, 4, 0, 0);

    // Sweep over add sizes, completion gaps and retire splits on a 16-entry ring
    for (int n = 1; n <= 6; n++) begin
      int c = 0;
      step("R2", 1, 2, n, 0);
      while (m_avail != 0 && c < 100) begin
        if (m_pend > 0 && c % 4 == 1) step("R12", 1, 3, 1, (c % 3) != 0);
        else step("R4", 0, 0, 0, (c % 3) != 0);
        c++;
      end
      if (m_pend > 1) step("R5", 1, 3, m_pend / 2, 0);
      step("R5", 1, 3, m_pend, 0);
    end

    // R12: completion and retire in the same cycle
    step("R2", 1, 2, 2, 0);
    step("R4", 0, 0, 0, 1);
    step("R12", 1, 3, 1, 1);
    chk("R12", "combined_pending", longint'(done_status[14:0]), 1);
    step("R5", 1, 3, 1, 0);

    // R6: over-retire saturates and latches the error
    step("R2", 1, 2, 2, 0);
    drain("R4");
    step("R6", 1, 3, 5, 0);
    chk("R6", "saturated", longint'(done_status[14:0]), 0);
    chk("R6", "err_set", longint'(dealloc_err), 1);
    step("R6", 1, 2, 1, 0);
    drain("R6");
    step("R6", 1, 3, 1, 0);
    chk("R6", "err_sticky", longint'(dealloc_err), 1);

    // R10: size written while running is deferred
    begin
      int k = (16 - m_proc) % 16;
      if (k > 0) begin
        step("R10", 1, 2, k, 0);
        drain("R10");
        step("R10", 1, 3, k, 0);
      end
    end
    step("R10", 1, 0, 8, 0);
    step("R2", 1, 2, 10, 0);
    drain("R10");
    chk("R10", "old_size_kept", longint'(fetch_idx), 10);
    step("R10", 1, 3, 10, 0);
    step("R2", 1, 2, 6, 0);
    drain("R10");
    step("R10", 1, 3, 6, 0);
    step("R9", 1, 4, 1, 0);
    step("R10", 1, 0, 0, 0);
    step("R10", 1, 0, 9000, 0);
    step("R10", 0, 0, 0, 0);
    step("R9", 1, 4, 0, 0);
    step("R2", 1, 2, 9, 0);
    drain("R10");
    chk("R10", "new_size_wrap", longint'(fetch_idx), 1);
    step("R10", 1, 3, 9, 0);
    chk("R10", "retire_new_size", longint'(done_status[28:16]), 1);
    chk("R7", "status_word", longint'(done_status), longint'(32'd1 << 16));

    summary();
    $finish;
  end
endmodule